// File: doc/BRIEF.md
# Stream Replay Prefetch Generator

This block turns demand access addresses into prefetch addresses by replaying spatial region records kept in an external circular history log. Each record holds a trigger block address and two bit vectors. The first vector marks blocks below the trigger, the second marks blocks above it. Bit `i` of either vector stands for a distance of `i+1` blocks from the trigger.

The block tracks a small set of active streams, ordered from oldest to youngest. Each stream holds a pointer into the log and a local copy of the record at that pointer. An accepted access is first compared against every active stream. If a stream covers the access, that stream moves to the next log position and the record found there is expanded into prefetches. If no stream covers the access, an external trigger index is consulted. An index hit opens a new stream at the indexed log position and expands that record. An access that finds neither produces nothing.

Expanded addresses leave one per cycle on a valid/ready port. Each access is taken in a single handshake and fully processed before the next access is accepted.

Top module: `sabpf_gen`

## Requirements
- R1: After reset, `acc_ready_o` is 1, and `pf_valid_o`, `hist_req_o` and `idx_req_o` are 0.
- R2: A stream covers an access in either of two cases. The first is when the access block (address shifted right by BLK_LOG) equals the stream's trigger block. The second is when the block lies d blocks above (or below) the trigger, d does not exceed SUCC_W (or PREC_W), and bit d-1 of the succeeding (or preceding) vector is 1. In every other case the stream does not cover the access.
- R3: A covering stream advances its pointer by one, wrapping from HIST_DEPTH-1 to 0. The block then issues exactly one history read at the new pointer and expands the record returned.
- R4: Streams are compared oldest first. Only the oldest covering stream advances; other streams keep their pointers.
- R5: When no stream covers the access, the block asserts `idx_req_o` with `idx_blk_o` equal to the access block. On `idx_hit_i`, it opens a stream at `idx_ptr_i`, reads that history position, and expands the record. When a stream covers the access, no index request is made.
- R6: When NUM_STREAMS streams are open, opening another evicts the oldest one. An evicted stream no longer covers accesses.
- R7: A record expands in a fixed order. Set preceding bits come first, from the highest index to the lowest, each giving `(trigger - (i+1)) << BLK_LOG`. Set succeeding bits follow, from the lowest index to the highest, each giving `(trigger + (i+1)) << BLK_LOG`.
- R8: At most one prefetch address is transferred per cycle. While `pf_valid_o` is 1 and `pf_ready_i` is 0, both `pf_valid_o` and `pf_addr_o` hold their values.
- R9: `acc_ready_o` stays 0 from the accepted access until its expansion has finished, so `pf_valid_o` and `acc_ready_o` are never 1 together.
- R10: An access that misses both the streams and the index produces no prefetch and no history read, and `acc_ready_o` returns to 1 on the next cycle.
- R11: Each accepted access causes at most one history read, lasting a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access address valid |
| acc_ready_o | output | 1 | Block can take an access |
| acc_addr_i | input | ADDR_W | Access byte address |
| idx_req_o | output | 1 | Trigger index lookup strobe |
| idx_blk_o | output | ADDR_W-BLK_LOG | Block address being looked up |
| idx_hit_i | input | 1 | Index holds the block (same cycle) |
| idx_ptr_i | input | log2(HIST_DEPTH) | History position returned by the index |
| hist_req_o | output | 1 | History read strobe |
| hist_ptr_o | output | log2(HIST_DEPTH) | History position being read |
| hist_trig_i | input | ADDR_W-BLK_LOG | Trigger block of the record read (same cycle) |
| hist_prec_i | input | PREC_W | Preceding-block vector of the record read |
| hist_succ_i | input | SUCC_W | Succeeding-block vector of the record read |
| pf_valid_o | output | 1 | Prefetch address valid |
| pf_ready_i | input | 1 | Prefetch consumer ready |
| pf_addr_o | output | ADDR_W | Prefetch byte address |

## Verification
The bench builds the block with two streams, a four-entry history log, 16-byte blocks, a 3-bit preceding vector and a 4-bit succeeding vector. With only two streams, a third allocation forces an eviction after a few accesses. The four-entry log lets a stream replay far enough to wrap its pointer to zero more than once. The short vectors put coverage at the edge of each vector, a clear bit, and an out-of-reach block within a handful of directed accesses. Two streams that copy the same record make the oldest-first choice visible at the ports.

// File: rtl/sabpf_pkg.sv
package sabpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_LOAD,
    ST_EMIT
  } sab_state_e;
endpackage

// File: rtl/sabpf_cover.sv
module sabpf_cover #(
  parameter int NUM_STREAMS = 4,
  parameter int BLK_W       = 26,
  parameter int PREC_W      = 4,
  parameter int SUCC_W      = 8,
  parameter int SLOT_W      = 2
) (
  input  logic [BLK_W-1:0]                    blk_i,
  input  logic [NUM_STREAMS-1:0]              vld_i,
  input  logic [NUM_STREAMS-1:0][BLK_W-1:0]   trig_i,
  input  logic [NUM_STREAMS-1:0][PREC_W-1:0]  prec_i,
  input  logic [NUM_STREAMS-1:0][SUCC_W-1:0]  succ_i,
  output logic                                hit_o,
  output logic [SLOT_W-1:0]                   slot_o
);
  localparam int PIW = $clog2(PREC_W + 1);
  localparam int SIW = $clog2(SUCC_W + 1);

  logic [NUM_STREAMS-1:0] cov;

  for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_slot
    logic             above, below, same;
    logic [BLK_W-1:0] d_up, d_dn;
    logic [SUCC_W:0]  succ_ext;
    logic [PREC_W:0]  prec_ext;
    logic             up_bit, dn_bit;

    assign same     = blk_i == trig_i[k];
    assign above    = blk_i > trig_i[k];
    assign below    = blk_i < trig_i[k];
    assign d_up     = blk_i - trig_i[k];
    assign d_dn     = trig_i[k] - blk_i;
    // bit 0 of the extended vector is distance 0, never set
    assign succ_ext = {succ_i[k], 1'b0};
    assign prec_ext = {prec_i[k], 1'b0};
    assign up_bit   = (d_up <= BLK_W'(SUCC_W)) ? succ_ext[d_up[SIW-1:0]] : 1'b0;
    assign dn_bit   = (d_dn <= BLK_W'(PREC_W)) ? prec_ext[d_dn[PIW-1:0]] : 1'b0;
    assign cov[k]   = vld_i[k] && (same || (above && up_bit) || (below && dn_bit));
  end

  // lowest slot is the oldest stream
  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    for (int k = NUM_STREAMS - 1; k >= 0; k--) begin
      if (cov[k]) begin
        hit_o  = 1'b1;
        slot_o = SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/sabpf_stream_fifo.sv
module sabpf_stream_fifo #(
  parameter int NUM_STREAMS = 4,
  parameter int PTR_W       = 4,
  parameter int BLK_W       = 26,
  parameter int PREC_W      = 4,
  parameter int SUCC_W      = 8,
  parameter int SLOT_W      = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                adv_en_i,
  input  logic [SLOT_W-1:0]                   adv_slot_i,
  input  logic [PTR_W-1:0]                    adv_ptr_i,
  input  logic                                alloc_en_i,
  input  logic [PTR_W-1:0]                    alloc_ptr_i,
  output logic [SLOT_W-1:0]                   alloc_slot_o,
  input  logic                                rec_we_i,
  input  logic [SLOT_W-1:0]                   rec_slot_i,
  input  logic [BLK_W-1:0]                    rec_trig_i,
  input  logic [PREC_W-1:0]                   rec_prec_i,
  input  logic [SUCC_W-1:0]                   rec_succ_i,
  output logic [NUM_STREAMS-1:0]              vld_o,
  output logic [NUM_STREAMS-1:0][PTR_W-1:0]   ptr_o,
  output logic [NUM_STREAMS-1:0][BLK_W-1:0]   trig_o,
  output logic [NUM_STREAMS-1:0][PREC_W-1:0]  prec_o,
  output logic [NUM_STREAMS-1:0][SUCC_W-1:0]  succ_o
);
  localparam int CNT_W = $clog2(NUM_STREAMS + 1);

  logic [CNT_W-1:0]                  cnt_q;
  logic [NUM_STREAMS-1:0][PTR_W-1:0]  ptr_q;
  logic [NUM_STREAMS-1:0][BLK_W-1:0]  trig_q;
  logic [NUM_STREAMS-1:0][PREC_W-1:0] prec_q;
  logic [NUM_STREAMS-1:0][SUCC_W-1:0] succ_q;
  logic                              full;

  assign full         = cnt_q == CNT_W'(NUM_STREAMS);
  assign alloc_slot_o = full ? SLOT_W'(NUM_STREAMS - 1) : SLOT_W'(cnt_q);

  for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_vld
    assign vld_o[k] = CNT_W'(k) < cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ptr_q  <= '0;
      trig_q <= '0;
      prec_q <= '0;
      succ_q <= '0;
    end else begin
      if (alloc_en_i) begin
        if (full) begin
          // drop the oldest, shift the rest down
          for (int k = 0; k < NUM_STREAMS - 1; k++) begin
            ptr_q[k]  <= ptr_q[k+1];
            trig_q[k] <= trig_q[k+1];
            prec_q[k] <= prec_q[k+1];
            succ_q[k] <= succ_q[k+1];
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ptr_q[alloc_slot_o]  <= alloc_ptr_i;
        trig_q[alloc_slot_o] <= '0;
        prec_q[alloc_slot_o] <= '0;
        succ_q[alloc_slot_o] <= '0;
      end
      if (adv_en_i) ptr_q[adv_slot_i] <= adv_ptr_i;
      if (rec_we_i) begin
        trig_q[rec_slot_i] <= rec_trig_i;
        prec_q[rec_slot_i] <= rec_prec_i;
        succ_q[rec_slot_i] <= rec_succ_i;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign trig_o = trig_q;
  assign prec_o = prec_q;
  assign succ_o = succ_q;
endmodule

// File: rtl/sabpf_expand.sv
module sabpf_expand #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LOG = 6,
  parameter int BLK_W   = 26,
  parameter int PREC_W  = 4,
  parameter int SUCC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BLK_W-1:0]  trig_i,
  input  logic [PREC_W-1:0] prec_i,
  input  logic [SUCC_W-1:0] succ_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BLK_W-1:0]  trig_q;
  logic [PREC_W-1:0] prec_q, prec_clr;
  logic [SUCC_W-1:0] succ_q, succ_clr;
  logic              use_prec;
  logic [BLK_W-1:0]  off_p, off_s, blk;

  assign use_prec = |prec_q;
  assign valid_o  = use_prec || (|succ_q);

  // farthest preceding block first
  always_comb begin
    prec_clr = '0;
    off_p    = '0;
    for (int i = 0; i < PREC_W; i++) begin
      if (prec_q[i]) begin
        prec_clr    = '0;
        prec_clr[i] = 1'b1;
        off_p       = BLK_W'(i + 1);
      end
    end
  end

  // nearest succeeding block first
  always_comb begin
    succ_clr = '0;
    off_s    = '0;
    for (int i = SUCC_W - 1; i >= 0; i--) begin
      if (succ_q[i]) begin
        succ_clr    = '0;
        succ_clr[i] = 1'b1;
        off_s       = BLK_W'(i + 1);
      end
    end
  end

  assign blk    = use_prec ? (trig_q - off_p) : (trig_q + off_s);
  assign addr_o = {blk, {BLK_LOG{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      prec_q <= '0;
      succ_q <= '0;
    end else if (load_i) begin
      trig_q <= trig_i;
      prec_q <= prec_i;
      succ_q <= succ_i;
    end else if (valid_o && ready_i) begin
      if (use_prec) prec_q <= prec_q & ~prec_clr;
      else          succ_q <= succ_q & ~succ_clr;
    end
  end
endmodule

// File: rtl/sabpf_gen.sv
module sabpf_gen #(
  parameter int ADDR_W      = 32,
  parameter int BLK_LOG     = 6,
  parameter int PREC_W      = 4,
  parameter int SUCC_W      = 8,
  parameter int NUM_STREAMS = 4,
  parameter int HIST_DEPTH  = 16,
  localparam int BLK_W      = ADDR_W - BLK_LOG,
  localparam int PTR_W      = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              idx_req_o,
  output logic [BLK_W-1:0]  idx_blk_o,
  input  logic              idx_hit_i,
  input  logic [PTR_W-1:0]  idx_ptr_i,
  output logic              hist_req_o,
  output logic [PTR_W-1:0]  hist_ptr_o,
  input  logic [BLK_W-1:0]  hist_trig_i,
  input  logic [PREC_W-1:0] hist_prec_i,
  input  logic [SUCC_W-1:0] hist_succ_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o
);
  import sabpf_pkg::*;

  localparam int SLOT_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

  sab_state_e       state_q, state_d;
  logic [BLK_W-1:0]  blk_q;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;

  logic [NUM_STREAMS-1:0]              s_vld;
  logic [NUM_STREAMS-1:0][PTR_W-1:0]   s_ptr;
  logic [NUM_STREAMS-1:0][BLK_W-1:0]   s_trig;
  logic [NUM_STREAMS-1:0][PREC_W-1:0]  s_prec;
  logic [NUM_STREAMS-1:0][SUCC_W-1:0]  s_succ;

  logic              cov_hit;
  logic [SLOT_W-1:0] cov_slot;
  logic [SLOT_W-1:0] alloc_slot;
  logic [PTR_W-1:0]  cur_ptr, nxt_ptr;
  logic              adv_en, alloc_en, load_en, exp_busy;

  sabpf_cover #(
    .NUM_STREAMS(NUM_STREAMS), .BLK_W(BLK_W), .PREC_W(PREC_W),
    .SUCC_W(SUCC_W), .SLOT_W(SLOT_W)
  ) u_cover (
    .blk_i (blk_q),
    .vld_i (s_vld),
    .trig_i(s_trig),
    .prec_i(s_prec),
    .succ_i(s_succ),
    .hit_o (cov_hit),
    .slot_o(cov_slot)
  );

  assign cur_ptr = s_ptr[cov_slot];
  assign nxt_ptr = (cur_ptr == PTR_W'(HIST_DEPTH - 1)) ? '0 : cur_ptr + 1'b1;

  always_comb begin
    state_d   = state_q;
    slot_d    = slot_q;
    ptr_d     = ptr_q;
    adv_en    = 1'b0;
    alloc_en  = 1'b0;
    load_en   = 1'b0;
    idx_req_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (acc_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (cov_hit) begin
          adv_en  = 1'b1;
          slot_d  = cov_slot;
          ptr_d   = nxt_ptr;
          state_d = ST_LOAD;
        end else begin
          idx_req_o = 1'b1;
          if (idx_hit_i) begin
            alloc_en = 1'b1;
            slot_d   = alloc_slot;
            ptr_d    = idx_ptr_i;
            state_d  = ST_LOAD;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_LOAD: begin
        load_en = 1'b1;
        state_d = ST_EMIT;
      end
      ST_EMIT: if (!exp_busy) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      slot_q  <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      ptr_q   <= ptr_d;
      if (state_q == ST_IDLE && acc_valid_i) blk_q <= acc_addr_i[ADDR_W-1:BLK_LOG];
    end
  end

  sabpf_stream_fifo #(
    .NUM_STREAMS(NUM_STREAMS), .PTR_W(PTR_W), .BLK_W(BLK_W),
    .PREC_W(PREC_W), .SUCC_W(SUCC_W), .SLOT_W(SLOT_W)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_en_i    (adv_en),
    .adv_slot_i  (cov_slot),
    .adv_ptr_i   (nxt_ptr),
    .alloc_en_i  (alloc_en),
    .alloc_ptr_i (idx_ptr_i),
    .alloc_slot_o(alloc_slot),
    .rec_we_i    (load_en),
    .rec_slot_i  (slot_q),
    .rec_trig_i  (hist_trig_i),
    .rec_prec_i  (hist_prec_i),
    .rec_succ_i  (hist_succ_i),
    .vld_o       (s_vld),
    .ptr_o       (s_ptr),
    .trig_o      (s_trig),
    .prec_o      (s_prec),
    .succ_o      (s_succ)
  );

  sabpf_expand #(
    .ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG), .BLK_W(BLK_W),
    .PREC_W(PREC_W), .SUCC_W(SUCC_W)
  ) u_expand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .trig_i (hist_trig_i),
    .prec_i (hist_prec_i),
    .succ_i (hist_succ_i),
    .valid_o(exp_busy),
    .ready_i(pf_ready_i),
    .addr_o (pf_addr_o)
  );

  assign acc_ready_o = state_q == ST_IDLE;
  assign idx_blk_o   = blk_q;
  assign hist_req_o  = load_en;
  assign hist_ptr_o  = ptr_q;
  assign pf_valid_o  = exp_busy;
endmodule

// File: rtl/sabpf_gen_chk.sv
module sabpf_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 4,
  parameter int HIST_DEPTH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_ready_o,
  input logic              idx_req_o,
  input logic              idx_hit_i,
  input logic              hist_req_o,
  input logic [PTR_W-1:0]  hist_ptr_o,
  input logic              pf_valid_o,
  input logic              pf_ready_i,
  input logic [ADDR_W-1:0] pf_addr_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ready_o |-> (!pf_valid_o && !hist_req_o));

  p_hist_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_req_o |-> ({1'b0, hist_ptr_o} < (PTR_W+1)'(HIST_DEPTH)));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_addr_o)));

  p_no_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> !acc_ready_o);

  p_miss_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_req_o && !idx_hit_i) |=> (acc_ready_o && !hist_req_o));

  p_single_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_req_o |=> (!hist_req_o && !acc_ready_o));
endmodule

bind sabpf_gen sabpf_gen_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .HIST_DEPTH(HIST_DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_ready_o(acc_ready_o),
  .idx_req_o  (idx_req_o),
  .idx_hit_i  (idx_hit_i),
  .hist_req_o (hist_req_o),
  .hist_ptr_o (hist_ptr_o),
  .pf_valid_o (pf_valid_o),
  .pf_ready_i (pf_ready_i),
  .pf_addr_o  (pf_addr_o)
);

// File: tb/sabpf_gen_bench.sv
`timescale 1ns/1ps
module sabpf_gen_bench;
  localparam int ADDR_W = 16;
  localparam int BLK_LOG = 4;
  localparam int PREC_W = 3;
  localparam int SUCC_W = 4;
  localparam int NUM_STREAMS = 2;
  localparam int HIST_DEPTH = 4;
  localparam int BLK_W = ADDR_W - BLK_LOG;
  localparam int PTR_W = 2;
  localparam time CLK_P = 20ns;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic acc_valid_i = 1'b0;
  logic acc_ready_o;
  logic [ADDR_W-1:0] acc_addr_i = '0;
  logic idx_req_o;
  logic [BLK_W-1:0] idx_blk_o;
  logic idx_hit_i;
  logic [PTR_W-1:0] idx_ptr_i;
  logic hist_req_o;
  logic [PTR_W-1:0] hist_ptr_o;
  logic [BLK_W-1:0] hist_trig_i;
  logic [PREC_W-1:0] hist_prec_i;
  logic [SUCC_W-1:0] hist_succ_i;
  logic pf_valid_o;
  logic pf_ready_i = 1'b1;
  logic [ADDR_W-1:0] pf_addr_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  sabpf_gen #(
    .ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG), .PREC_W(PREC_W), .SUCC_W(SUCC_W),
    .NUM_STREAMS(NUM_STREAMS), .HIST_DEPTH(HIST_DEPTH)
  ) u_sabpf_gen (.*);

  // history log and trigger index models
  logic [BLK_W-1:0]  h_trig [HIST_DEPTH];
  logic [PREC_W-1:0] h_prec [HIST_DEPTH];
  logic [SUCC_W-1:0] h_succ [HIST_DEPTH];
  logic [BLK_W-1:0]  ix_key [4];
  logic [PTR_W-1:0]  ix_val [4];

  initial begin
    h_trig[0] = 12'h100; h_prec[0] = 3'b101; h_succ[0] = 4'b0011;
    h_trig[1] = 12'h200; h_prec[1] = 3'b000; h_succ[1] = 4'b1000;
    h_trig[2] = 12'h300; h_prec[2] = 3'b010; h_succ[2] = 4'b0000;
    h_trig[3] = 12'h400; h_prec[3] = 3'b000; h_succ[3] = 4'b0101;
    ix_key[0] = 12'h100; ix_val[0] = 2'd0;
    ix_key[1] = 12'h300; ix_val[1] = 2'd2;
    ix_key[2] = 12'h400; ix_val[2] = 2'd3;
    ix_key[3] = 12'h500; ix_val[3] = 2'd0;
  end

  always_comb begin
    hist_trig_i = h_trig[hist_ptr_o];
    hist_prec_i = h_prec[hist_ptr_o];
    hist_succ_i = h_succ[hist_ptr_o];
    idx_hit_i = 1'b0;
    idx_ptr_i = '0;
    for (int i = 0; i < 4; i++) begin
      if (ix_key[i] == idx_blk_o) begin
        idx_hit_i = 1'b1;
        idx_ptr_i = ix_val[i];
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int busy_viol = 0;
  logic stall_mode = 1'b0;

  logic [ADDR_W-1:0] out_q[$];
  logic [PTR_W-1:0]  rd_q[$];
  logic [BLK_W-1:0]  ix_q[$];
  logic [ADDR_W-1:0] exp_q[$];

  always @(posedge clk_i) begin
    #1;
    pf_ready_i = stall_mode ? !pf_ready_i : 1'b1;
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pf_valid_o && pf_ready_i) out_q.push_back(pf_addr_o);
      if (hist_req_o) rd_q.push_back(hist_ptr_o);
      if (idx_req_o) ix_q.push_back(idx_blk_o);
      if (pf_valid_o && acc_ready_o) busy_viol++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build_exp(input int p);
    exp_q.delete();
    for (int i = PREC_W - 1; i >= 0; i--)
      if (h_prec[p][i]) exp_q.push_back({h_trig[p] - BLK_W'(i + 1), 4'h0});
    for (int i = 0; i < SUCC_W; i++)
      if (h_succ[p][i]) exp_q.push_back({h_trig[p] + BLK_W'(i + 1), 4'h0});
  endtask

  task automatic access(input logic [BLK_W-1:0] blk);
    out_q.delete(); rd_q.delete(); ix_q.delete();
    @(negedge clk_i);
    acc_addr_i = {blk, 4'h7};
    acc_valid_i = 1'b1;
    while (!acc_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 acc_valid_i = 1'b0;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk_i);
      if (acc_ready_o) break;
    end
  endtask

  // exp_ptr < 0 means no read and no prefetch expected
  task automatic expect_result(input string req, input int exp_ptr, input int exp_ix);
    if (exp_ptr >= 0) begin
      build_exp(exp_ptr);
      check(rd_q.size() == 1, req, "history read count", rd_q.size(), 1);
      if (rd_q.size() == 1) check(rd_q[0] == PTR_W'(exp_ptr), req, "history pointer", rd_q[0], exp_ptr);
      check(out_q.size() == exp_q.size(), req, "prefetch count", out_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < out_q.size(); i++)
        check(out_q[i] == exp_q[i], req, "prefetch address", out_q[i], exp_q[i]);
    end else begin
      check(rd_q.size() == 0, req, "history read count", rd_q.size(), 0);
      check(out_q.size() == 0, req, "prefetch count", out_q.size(), 0);
    end
    check(ix_q.size() == exp_ix, req, "index request count", ix_q.size(), exp_ix);
  endtask

  task automatic t_reset;
    #1;
    check(acc_ready_o == 1'b1, "R1", "acc_ready", acc_ready_o, 1);
    check(pf_valid_o == 1'b0, "R1", "pf_valid", pf_valid_o, 0);
    check(hist_req_o == 1'b0 && idx_req_o == 1'b0, "R1", "strobes", {hist_req_o, idx_req_o}, 0);
  endtask

  task automatic t_miss_all;
    access(12'h777);
    expect_result("R10", -1, 1);
    if (ix_q.size() == 1) check(ix_q[0] == 12'h777, "R5", "lookup block", ix_q[0], 12'h777);
  endtask

  task automatic t_index_alloc;
    access(12'h100);              // stream A at 0
    expect_result("R5_R7", 0, 1);
  endtask

  task automatic t_cover_advance;
    access(12'h101);              // succ bit 0 of rec 0, A -> 1
    expect_result("R2_R3", 1, 0);
    access(12'h200);              // trigger equality, A -> 2
    expect_result("R2", 2, 0);
    access(12'h2FE);              // preceding side d=2, A -> 3
    expect_result("R2", 3, 0);
    access(12'h403);              // succ bit 2 of rec 3, wrap A -> 0
    expect_result("R3", 0, 0);
    access(12'h103);              // succ bit 2 clear in rec 0: not covered, index miss
    expect_result("R2", -1, 1);
    access(12'h0FB);              // d=5 beyond preceding length
    expect_result("R2", -1, 1);
  endtask

  task automatic t_oldest_first;
    access(12'h500);              // index -> 0, stream B copies rec 0
    expect_result("R5", 0, 1);
    access(12'h101);              // both cover, A (oldest) -> 1
    expect_result("R4", 1, 0);
    access(12'h102);              // only B covers, B still at 0 -> 1
    expect_result("R4", 1, 0);
  endtask

  task automatic t_evict;
    access(12'h200);              // A -> 2 (rec trig 0x300)
    expect_result("R4", 2, 0);
    access(12'h400);              // full: evict A, C at 3
    expect_result("R6", 3, 1);
    access(12'h2FE);              // only evicted A covered this
    expect_result("R6", -1, 1);
    access(12'h200);              // B kept, B -> 2
    expect_result("R6", 2, 0);
  endtask

  task automatic t_stall;
    stall_mode = 1'b1;
    access(12'h401);              // C covers, wraps 3 -> 0, 4 addresses under stall
    expect_result("R8_R3", 0, 0);
    stall_mode = 1'b0;
    check(busy_viol == 0, "R9", "ready while prefetch pending", busy_viol, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    t_reset();
    t_miss_all();
    t_index_alloc();
    t_cover_advance();
    t_oldest_first();
    t_evict();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule